// File: doc/BRIEF.md
# Read Burst Truncation Command Scheduler

This block sits on the controller side of a double-data-rate memory channel and owns the command bus of a single open bank. A requester hands it read and write requests through a one-entry valid/ready slot. A read request carries a start column, the number of element pairs it actually wants and an auto-precharge flag. It may also ask that the read be cut with a precharge rather than a burst terminate. The scheduler issues the READ and then works out the exact cycle for the command that cuts the burst short. That command is the next READ if one is waiting, otherwise a precharge or a burst terminate. A WRITE waits until the read data has left the bus.

The requester applies back-pressure rules only at the slot. `req_ready` is high whenever the slot is empty. A request moves in on a rising edge where both `req_valid` and `req_ready` are high. Fields presented while `req_ready` is low are not sampled. The command output is registered and one-hot, with a dedicated NOP bit. `busy_o` tells the requester that a request is still in flight. Row activation, refresh, multi-bank operation and data capture are handled elsewhere.

Top module: `rdtrunc_sched`

## Requirements
- R1: `cmd_o` is one-hot at all times with bit 0 = NOP, bit 1 = READ, bit 2 = WRITE, bit 3 = BURST TERMINATE, bit 4 = PRECHARGE. Every cycle without a command shows NOP. During and right after reset, `cmd_o` is NOP, `busy_o` is 0 and `req_ready` is 1.
- R2: The request slot holds one request. `req_ready` is 0 while a request is held and 1 otherwise. A request is taken on an edge with `req_valid` and `req_ready` both high, and it leads to exactly one READ or WRITE.
- R3: READ and WRITE drive the request's column on `addr_o` and its flag on `ap_o`. NOP, BURST TERMINATE and PRECHARGE drive `addr_o` = 0 and `ap_o` = 0.
- R4: A read runs the full burst of BL/2 pairs when its pair count is 0, when its pair count exceeds BL/2, or when its auto-precharge flag is 1. A full burst never gets a BURST TERMINATE or a PRECHARGE.
- R5: A read with P pairs (1 <= P < BL/2), no auto precharge and no precharge-cut request is followed by a BURST TERMINATE exactly P cycles after its READ, unless a READ is waiting then.
- R6: A read with P < BL/2, no auto precharge and the precharge-cut flag set is followed by a PRECHARGE exactly P cycles after its READ, unless a READ is waiting then.
- R7: A READ request that is waiting while a burst is open is issued exactly P cycles after the open READ, where P is that read's effective pair count. For a full burst this is BL/2 cycles. This READ replaces the truncating command.
- R8: A WRITE is issued no earlier than CL+1 cycles after the end of the previous read. The end is the cycle of its cutting command, or BL/2 cycles after the READ for a full burst. The WRITE appears in exactly that cycle if it is already waiting.
- R9: `busy_o` is high while a request is held, or while a truncated read's cutting command has not yet been issued. Otherwise it is low.
- R10: When nothing blocks it, a request's command appears on `cmd_o` in the cycle after the edge that follows its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slot empty, request will be taken |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_col | input | COLW | Start column |
| req_pairs | input | PW | Wanted element pairs (reads) |
| req_ap | input | 1 | Auto-precharge flag |
| req_pre_cut | input | 1 | Cut a short read with PRECHARGE instead of BURST TERMINATE |
| cmd_o | output | 5 | One-hot command |
| addr_o | output | COLW | Column address of the command |
| ap_o | output | 1 | Auto-precharge bit of the command |
| busy_o | output | 1 | Request still in flight |

## Verification
The assertions run on every cycle. They cover the one-hot command, the zero address on non-column commands, and the placement of any cutting command strictly inside an uncut burst. They also check that no precharge cuts an auto-precharge read, that the write gap after a read's end is respected, and that busy is high whenever the slot is full. Some properties need a known request stream, so only the bench scenarios show them. These are the exact cycle of each cutting command, a chained READ replacing the terminate, the full-burst promotion for zero, oversized and auto-precharge pair counts, and the exact write placement at the CL+1 boundary.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_BST = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  localparam int NUM_OPS = 5;
endpackage

// File: rtl/rts_slot.sv
module rts_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         pop
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rts_ctl.sv
module rts_ctl
  import rts_pkg::*;
#(
  parameter int BL   = 8,
  parameter int CL   = 3,
  parameter int COLW = 10,
  parameter int PW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend_valid,
  input  logic            pend_write,
  input  logic [COLW-1:0] pend_col,
  input  logic [PW-1:0]   pend_pairs,
  input  logic            pend_ap,
  input  logic            pend_pre,
  output op_e             op_nxt,
  output logic [COLW-1:0] col_nxt,
  output logic            ap_nxt,
  output logic            pop,
  output logic            cut_owed
);
  localparam int BLH = BL / 2;
  localparam int CW  = $clog2(BLH + 1);
  localparam int HW  = $clog2(CL + 2);

  logic          open_q, open_d;
  logic          owed_q, owed_d;
  logic          pre_q, pre_d;
  logic [CW-1:0] pairs_q, pairs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] hold_q, hold_d;

  logic          rd_wait, wr_wait, at_point, take_rd;
  logic [CW-1:0] eff_pairs;

  assign rd_wait  = pend_valid && !pend_write;
  assign wr_wait  = pend_valid && pend_write;
  assign at_point = open_q && (cnt_q == pairs_q - CW'(1));
  assign cut_owed = open_q && owed_q;

  always_comb begin
    if (pend_ap || pend_pairs == '0 || int'(pend_pairs) > BLH)
      eff_pairs = CW'(BLH);
    else
      eff_pairs = CW'(pend_pairs);
  end

  always_comb begin
    op_nxt  = OP_NOP;
    col_nxt = pend_col;
    ap_nxt  = pend_ap;
    pop     = 1'b0;
    take_rd = 1'b0;
    open_d  = open_q;
    owed_d  = owed_q;
    pre_d   = pre_q;
    pairs_d = pairs_q;
    cnt_d   = (cnt_q != CW'(BLH)) ? cnt_q + CW'(1) : cnt_q;
    hold_d  = (hold_q != '0) ? hold_q - HW'(1) : hold_q;

    if (open_q) begin
      if (at_point) begin
        if (rd_wait) begin
          take_rd = 1'b1;
        end else begin
          open_d = 1'b0;
          owed_d = 1'b0;
          hold_d = HW'(CL + 1);
          if (owed_q) op_nxt = pre_q ? OP_PRE : OP_BST;
        end
      end
    end else if (rd_wait) begin
      take_rd = 1'b1;
    end else if (wr_wait && hold_q <= HW'(1)) begin
      op_nxt = OP_WR;
      pop    = 1'b1;
    end

    if (take_rd) begin
      op_nxt  = OP_RD;
      pop     = 1'b1;
      open_d  = 1'b1;
      cnt_d   = '0;
      pairs_d = eff_pairs;
      owed_d  = eff_pairs < CW'(BLH);
      pre_d   = pend_pre && !pend_ap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      owed_q  <= 1'b0;
      pre_q   <= 1'b0;
      pairs_q <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      open_q  <= open_d;
      owed_q  <= owed_d;
      pre_q   <= pre_d;
      pairs_q <= pairs_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
    end
  end
endmodule

// File: rtl/rts_out.sv
module rts_out
  import rts_pkg::*;
#(
  parameter int COLW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  op_e                 op_nxt,
  input  logic [COLW-1:0]     col_nxt,
  input  logic                ap_nxt,
  output logic [NUM_OPS-1:0]  cmd_o,
  output logic [COLW-1:0]     addr_o,
  output logic                ap_o
);
  logic [NUM_OPS-1:0] hot;
  logic               col_cmd;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_hot
    assign hot[i] = (int'(op_nxt) == i);
  end

  assign col_cmd = (op_nxt == OP_RD) || (op_nxt == OP_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o  <= NUM_OPS'(1);
      addr_o <= '0;
      ap_o   <= 1'b0;
    end else begin
      cmd_o  <= hot;
      addr_o <= col_cmd ? col_nxt : '0;
      ap_o   <= col_cmd && ap_nxt;
    end
  end
endmodule

// File: rtl/rdtrunc_sched.sv
module rdtrunc_sched
  import rts_pkg::*;
#(
  parameter int BL   = 8,
  parameter int CL   = 3,
  parameter int COLW = 10,
  parameter int PW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [COLW-1:0] req_col,
  input  logic [PW-1:0]   req_pairs,
  input  logic            req_ap,
  input  logic            req_pre_cut,
  output logic [4:0]      cmd_o,
  output logic [COLW-1:0] addr_o,
  output logic            ap_o,
  output logic            busy_o
);
  localparam int RW = COLW + PW + 3;

  logic [RW-1:0]   in_word, pend_word;
  logic            pend_valid, pop, cut_owed;
  logic            pend_write, pend_ap, pend_pre;
  logic [COLW-1:0] pend_col, col_nxt;
  logic [PW-1:0]   pend_pairs;
  logic            ap_nxt;
  op_e             op_nxt;

  assign in_word = {req_write, req_ap, req_pre_cut, req_pairs, req_col};
  assign {pend_write, pend_ap, pend_pre, pend_pairs, pend_col} = pend_word;
  assign busy_o  = pend_valid || cut_owed;

  rts_slot #(.W(RW)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(in_word),
    .out_valid(pend_valid), .out_data(pend_word), .pop(pop)
  );

  rts_ctl #(.BL(BL), .CL(CL), .COLW(COLW), .PW(PW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .pend_valid(pend_valid), .pend_write(pend_write), .pend_col(pend_col),
    .pend_pairs(pend_pairs), .pend_ap(pend_ap), .pend_pre(pend_pre),
    .op_nxt(op_nxt), .col_nxt(col_nxt), .ap_nxt(ap_nxt),
    .pop(pop), .cut_owed(cut_owed)
  );

  rts_out #(.COLW(COLW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .op_nxt(op_nxt), .col_nxt(col_nxt), .ap_nxt(ap_nxt),
    .cmd_o(cmd_o), .addr_o(addr_o), .ap_o(ap_o)
  );
endmodule

// File: rtl/rdtrunc_sched_chk.sv
module rdtrunc_sched_chk #(
  parameter int BL   = 8,
  parameter int CL   = 3,
  parameter int COLW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [4:0]      cmd_o,
  input logic [COLW-1:0] addr_o,
  input logic            ap_o,
  input logic            busy_o
);
  localparam logic [7:0] BLH8  = 8'(BL / 2);
  localparam logic [7:0] CL8   = 8'(CL);
  localparam logic [7:0] FULL8 = 8'(BL / 2 + CL);

  logic [7:0] since_rd, since_cut;
  logic       rd_seen, cut_done, last_ap;
  logic       is_rd, is_wr, is_cut;

  assign is_rd  = cmd_o[1];
  assign is_wr  = cmd_o[2];
  assign is_cut = cmd_o[3] || cmd_o[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rd  <= '0;
      since_cut <= '0;
      rd_seen   <= 1'b0;
      cut_done  <= 1'b0;
      last_ap   <= 1'b0;
    end else begin
      since_rd  <= is_rd  ? 8'd1 : (since_rd  != 8'hff ? since_rd  + 8'd1 : since_rd);
      since_cut <= is_cut ? 8'd1 : (since_cut != 8'hff ? since_cut + 8'd1 : since_cut);
      if (is_rd) begin
        rd_seen  <= 1'b1;
        cut_done <= 1'b0;
        last_ap  <= ap_o;
      end else if (is_cut) begin
        cut_done <= 1'b1;
      end
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cmd_o)); // R1

  AST_QUIET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_rd || is_wr) |-> (addr_o == '0 && !ap_o)); // R3

  AST_CUT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    is_cut |-> (rd_seen && !cut_done && since_rd >= 8'd1 && since_rd < BLH8)); // R5

  AST_PRE_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o[4] |-> !last_ap); // R6

  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> (!rd_seen || (cut_done ? since_cut > CL8 : since_rd > FULL8))); // R8

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> busy_o); // R9
endmodule

bind rdtrunc_sched rdtrunc_sched_chk #(.BL(BL), .CL(CL), .COLW(COLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_o(cmd_o),
  .addr_o(addr_o), .ap_o(ap_o), .busy_o(busy_o)
);

// File: tb/rdtrunc_sched_bench.sv
module rdtrunc_sched_bench;
  localparam int BL = 8, CL = 3, COLW = 10, PW = 3;
  localparam logic [4:0] C_NOP = 5'b00001, C_RD = 5'b00010, C_WR = 5'b00100,
                         C_BST = 5'b01000, C_PRE = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0, req_pre_cut = 1'b0;
  logic [COLW-1:0] req_col = '0;
  logic [PW-1:0] req_pairs = '0;
  logic req_ready, ap_o, busy_o;
  logic [4:0] cmd_o;
  logic [COLW-1:0] addr_o;

  int cyc = 0, n_run = 0, n_fail = 0;

  typedef struct {
    int at; logic [4:0] cmd; logic [COLW-1:0] col; logic ap; string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rdtrunc_sched #(.BL(BL), .CL(CL), .COLW(COLW), .PW(PW)) u_rdtrunc_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_col(req_col), .req_pairs(req_pairs),
    .req_ap(req_ap), .req_pre_cut(req_pre_cut), .cmd_o(cmd_o),
    .addr_o(addr_o), .ap_o(ap_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_cmd(input int at, input logic [4:0] cmd,
                            input logic [COLW-1:0] col, input logic ap, input string tag);
    exp_t e;
    e.at = at; e.cmd = cmd; e.col = col; e.ap = ap; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic send(input logic wr, input logic [COLW-1:0] col, input logic [PW-1:0] pairs,
                      input logic ap, input logic pre, output int acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_col = col; req_pairs = pairs; req_ap = ap; req_pre_cut = pre;
    req_valid = 1'b1;
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_to(input int at);
    while (cyc < at) @(negedge clk);
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  // monitor: every non-NOP command must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && cmd_o != C_NOP) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected command", int'(cmd_o), int'(C_NOP));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.at, {e.tag, " cycle"}, cyc, e.at);
        chk(cmd_o == e.cmd, {e.tag, " cmd"}, int'(cmd_o), int'(e.cmd));
        chk(addr_o == e.col, {e.tag, " addr"}, int'(addr_o), int'(e.col));
        chk(ap_o == e.ap, {e.tag, " ap"}, int'(ap_o), int'(e.ap));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int a, b, t;
    repeat (3) @(negedge clk);
    chk(cmd_o == C_NOP, "R1 reset cmd", int'(cmd_o), int'(C_NOP));
    chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_o == C_NOP, "R1 idle after reset", int'(cmd_o), int'(C_NOP));

    // R10 R3: write from idle
    send(1'b1, 10'h2a5, 3'd0, 1'b1, 1'b0, a);
    expect_cmd(a + 1, C_WR, 10'h2a5, 1'b1, "R10 write latency");
    settle();

    // R4: pair count 0 runs full burst
    send(1'b0, 10'h012, 3'd0, 1'b0, 1'b0, a);
    expect_cmd(a + 1, C_RD, 10'h012, 1'b0, "R4 zero pairs read");
    settle();

    // R5 R9: terminate two pairs in
    send(1'b0, 10'h040, 3'd2, 1'b0, 1'b0, a);
    t = a + 1;
    expect_cmd(t, C_RD, 10'h040, 1'b0, "R5 read");
    expect_cmd(t + 2, C_BST, '0, 1'b0, "R5 terminate");
    wait_to(t + 1);
    chk(busy_o == 1'b1, "R9 busy while cut owed", int'(busy_o), 1);
    wait_to(t + 3);
    chk(busy_o == 1'b0, "R9 busy after cut", int'(busy_o), 0);
    settle();

    // R6: precharge cut after one pair
    send(1'b0, 10'h081, 3'd1, 1'b0, 1'b1, a);
    t = a + 1;
    expect_cmd(t, C_RD, 10'h081, 1'b0, "R6 read");
    expect_cmd(t + 1, C_PRE, '0, 1'b0, "R6 precharge");
    settle();

    // R4 R8: auto precharge forces full burst, write after completion
    send(1'b0, 10'h0c3, 3'd3, 1'b1, 1'b1, a);
    t = a + 1;
    expect_cmd(t, C_RD, 10'h0c3, 1'b1, "R4 auto-precharge read");
    send(1'b1, 10'h0c8, 3'd0, 1'b0, 1'b0, b);
    expect_cmd(t + BL/2 + CL + 1, C_WR, 10'h0c8, 1'b0, "R8 write after full burst");
    settle();

    // R2 R7: chained read replaces terminate
    send(1'b0, 10'h100, 3'd2, 1'b0, 1'b0, a);
    t = a + 1;
    chk(req_ready == 1'b0, "R2 ready low while held", int'(req_ready), 0);
    expect_cmd(t, C_RD, 10'h100, 1'b0, "R7 first read");
    send(1'b0, 10'h104, 3'd4, 1'b0, 1'b0, b);
    expect_cmd(t + 2, C_RD, 10'h104, 1'b0, "R7 chained read");
    settle();

    // R5 R8: write behind truncated read gets terminate first
    send(1'b0, 10'h140, 3'd1, 1'b0, 1'b0, a);
    t = a + 1;
    expect_cmd(t, C_RD, 10'h140, 1'b0, "R5 read before write");
    expect_cmd(t + 1, C_BST, '0, 1'b0, "R5 terminate before write");
    send(1'b1, 10'h155, 3'd0, 1'b1, 1'b0, b);
    expect_cmd(t + 1 + CL + 1, C_WR, 10'h155, 1'b1, "R8 write after terminate");
    settle();

    // R7 R6: full burst concatenated with precharge-cut read
    send(1'b0, 10'h200, 3'd4, 1'b0, 1'b0, a);
    t = a + 1;
    expect_cmd(t, C_RD, 10'h200, 1'b0, "R7 full read");
    send(1'b0, 10'h204, 3'd2, 1'b0, 1'b1, b);
    expect_cmd(t + BL/2, C_RD, 10'h204, 1'b0, "R7 concatenated read");
    expect_cmd(t + BL/2 + 2, C_PRE, '0, 1'b0, "R6 precharge after chain");
    settle();

    // R4: oversized pair count runs full burst
    send(1'b0, 10'h300, 3'd7, 1'b0, 1'b0, a);
    expect_cmd(a + 1, C_RD, 10'h300, 1'b0, "R4 oversized pairs read");
    settle();

    chk(sb.size() == 0, "R2 all expected commands seen", sb.size(), 0);
    chk(busy_o == 1'b0, "R9 idle at end", int'(busy_o), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule